// File: doc/BRIEF.md
# In-System Flash Programming Controller

This block sits on a simple 32-bit register bus and lets software operate on an on-chip flash array one word at a time. Software loads an address, a data word and a command code, then writes a self-clearing start bit. The controller stays busy for a fixed number of cycles. When that time is over it performs the read, program, page erase, identification read or vector-page remap, and it clears the start bit. Software polls the start bit to learn when the operation has finished.

The array is modelled inside the block and holds four regions: application, data, loader and configuration. Each command is checked when it is started. An unknown command, a word address that is not aligned, an address that falls outside every region, or an update to a region whose enable is off sets a sticky fail flag. Such a command leaves the array untouched. A remap command moves the 512-byte window at byte addresses 0x000 to 0x1FF onto any 512-byte page. Every later operation address inside that window is translated through it.

Top module: `isp_flash_ctrl`

## Requirements
- R1: After reset the control (0x00), address (0x04), data (0x08), command (0x0C) and trigger (0x10) registers read 0. The status register (0x40) reads only the strap value CBS_VAL at bits [2:1], which is 0x6 by default. Every flash word reads 0xFFFFFFFF until it is programmed.
- R2: Writing a 1 to bit 0 at 0x10 while control bit 0 is set starts an operation. Bit 0 at 0x10 then reads 1 for exactly BUSY_CYCLES cycles, and status bit 0 shows the same value.
- R3: A write of 1 to bit 0 at 0x10 has no effect while control bit 0 (enable) is 0.
- R4: Command 0x21 ANDs the data register into the addressed word. Command 0x00 copies the addressed word into the data register.
- R5: Command 0x22 sets every word of the aligned 512-byte page that holds the address to 0xFFFFFFFF. Words in other pages keep their contents.
- R6: Command 0x0B loads 0xDA into the data register. Command 0x04 loads UID_BASE plus address bits [3:2].
- R7: Command 0x2E stores address bits [20:9] as the page value shown at status bits [20:9]. From then on, an operation address whose bits [31:9] are zero is used as {page, addr[8:0]}.
- R8: An unknown command sets the fail flag, which reads at control bit 6 and at status bit 6. So does a read, program or erase whose address has bits [1:0] not equal to 00 or lies outside every region. The array and the data register stay unchanged, and the trigger still clears after BUSY_CYCLES cycles.
- R9: Control bits are: 1 = boot region (0 application, 1 loader), 3 = application update enable, 4 = configuration update enable, 5 = loader update enable. A program or erase fails (R8 rules) in three cases: it targets configuration with bit 4 at 0; it targets the application region with bits 1 and 3 both at 0; or it targets the loader unless bit 1 is 0 and bit 5 is 1. Data-region updates are always allowed.
- R10: Writing 1 to bit 6 at 0x00 or at 0x40 clears the fail flag. Writing 0 there leaves it set.
- R11: While an operation is busy, writes to the control, address, data and command registers are ignored.
- R12: Offset 0x14 is read-only and reads the data-region base byte address (APP_BYTES, 0x400 by default), whose bits [8:0] are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, captured on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
The case that is hardest to reach from the ports is the effect of a remapped vector window on the other commands. The bench first programs words in two neighbouring pages and erases only one of those pages. It then remaps the window onto the data region, programs through a low address and reads the word back both through the window and at its physical address after the remap is undone. The protection rules are reached by changing the control enables between otherwise identical program commands. A further program command checks that register writes made while busy change nothing.

// File: rtl/isp_pkg.sv
package isp_pkg;

    typedef enum logic [5:0] {
        CMD_READ  = 6'h00,
        CMD_UID   = 6'h04,
        CMD_CID   = 6'h0B,
        CMD_PROG  = 6'h21,
        CMD_ERASE = 6'h22,
        CMD_REMAP = 6'h2E
    } isp_cmd_e;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_APP,
        RGN_DATA,
        RGN_LDR,
        RGN_CFG
    } rgn_e;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_ADDR = 8'h04;
    localparam logic [7:0] OFS_DATA = 8'h08;
    localparam logic [7:0] OFS_CMD  = 8'h0C;
    localparam logic [7:0] OFS_TRIG = 8'h10;
    localparam logic [7:0] OFS_DFB  = 8'h14;
    localparam logic [7:0] OFS_STAT = 8'h40;

    localparam logic [31:0] CID_VALUE = 32'h0000_00DA;

endpackage

// File: rtl/isp_addr_map.sv
module isp_addr_map
    import isp_pkg::*;
#(
    parameter logic [31:0] APP_BYTES = 32'h400,
    parameter logic [31:0] DF_BYTES  = 32'h200,
    parameter logic [31:0] LDR_BASE  = 32'h0010_0000,
    parameter logic [31:0] LDR_BYTES = 32'h200,
    parameter logic [31:0] CFG_BASE  = 32'h0030_0000,
    parameter logic [31:0] CFG_BYTES = 32'h8,
    parameter int          IDX_W     = 10
) (
    input  logic [31:0]      raw_addr,
    input  logic [11:0]      vec_page,
    output rgn_e             region,
    output logic [IDX_W-1:0] word_idx,
    output logic             misaligned
);
    localparam logic [31:0] DF_BASE = APP_BYTES;
    localparam logic [31:0] IDX_DF  = APP_BYTES >> 2;
    localparam logic [31:0] IDX_LDR = IDX_DF + (DF_BYTES >> 2);
    localparam logic [31:0] IDX_CFG = IDX_LDR + (LDR_BYTES >> 2);

    logic [31:0] xa;
    logic [31:0] idx_full;

    always_comb begin
        if (raw_addr[31:9] == '0) begin
            xa = {11'b0, vec_page, raw_addr[8:0]};
        end else begin
            xa = raw_addr;
        end
        region   = RGN_NONE;
        idx_full = '0;
        if (xa < APP_BYTES) begin
            region   = RGN_APP;
            idx_full = xa >> 2;
        end else if (xa >= DF_BASE && xa < DF_BASE + DF_BYTES) begin
            region   = RGN_DATA;
            idx_full = IDX_DF + ((xa - DF_BASE) >> 2);
        end else if (xa >= LDR_BASE && xa < LDR_BASE + LDR_BYTES) begin
            region   = RGN_LDR;
            idx_full = IDX_LDR + ((xa - LDR_BASE) >> 2);
        end else if (xa >= CFG_BASE && xa < CFG_BASE + CFG_BYTES) begin
            region   = RGN_CFG;
            idx_full = IDX_CFG + ((xa - CFG_BASE) >> 2);
        end
        word_idx   = idx_full[IDX_W-1:0];
        misaligned = (raw_addr[1:0] != 2'b00);
    end

endmodule

// File: rtl/isp_flash_array.sv
module isp_flash_array #(
    parameter int WORDS      = 514,
    parameter int PAGE_WORDS = 128,
    parameter int IDX_W      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic             er_en,
    input  logic [IDX_W-1:0] er_idx
);
    localparam int PG_SH = $clog2(PAGE_WORDS);

    logic [31:0] mem [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam logic [IDX_W-1:0] WI = IDX_W'(w);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[w] <= '1;
            end else if (er_en && (er_idx[IDX_W-1:PG_SH] == WI[IDX_W-1:PG_SH])) begin
                mem[w] <= '1;
            end else if (wr_en && (wr_idx == WI)) begin
                mem[w] <= mem[w] & wr_data;
            end
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/isp_flash_ctrl.sv
module isp_flash_ctrl
    import isp_pkg::*;
#(
    parameter logic [31:0] APP_BYTES   = 32'h400,
    parameter logic [31:0] DF_BYTES    = 32'h200,
    parameter logic [31:0] LDR_BASE    = 32'h0010_0000,
    parameter logic [31:0] LDR_BYTES   = 32'h200,
    parameter logic [31:0] CFG_BASE    = 32'h0030_0000,
    parameter logic [31:0] CFG_BYTES   = 32'h8,
    parameter int          BUSY_CYCLES = 4,
    parameter logic [1:0]  CBS_VAL     = 2'b11,
    parameter logic [31:0] UID_BASE    = 32'h5A00_1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    localparam int WORDS      = int'((APP_BYTES + DF_BYTES + LDR_BYTES + CFG_BYTES) >> 2);
    localparam int PAGE_WORDS = 128;
    localparam int IDX_W      = $clog2(WORDS);
    localparam int CNT_W      = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BUSY_CYCLES - 1);

    typedef struct packed {
        logic              isp_en;
        logic              boot;
        logic              app_en;
        logic              cfg_en;
        logic              ldr_en;
        logic              fail;
        logic              go;
        logic              op_bad;
        logic [31:0]       addr;
        logic [31:0]       data;
        logic [5:0]        cmd;
        logic [11:0]       vecmap;
        logic [CNT_W-1:0]  cnt;
    } st_t;

    st_t st_q, st_d;

    rgn_e             region;
    logic [IDX_W-1:0] word_idx;
    logic             misaligned;
    logic [31:0]      arr_rd;
    logic             arr_wr, arr_er;
    logic             bad_now;

    isp_addr_map #(
        .APP_BYTES(APP_BYTES), .DF_BYTES(DF_BYTES),
        .LDR_BASE(LDR_BASE), .LDR_BYTES(LDR_BYTES),
        .CFG_BASE(CFG_BASE), .CFG_BYTES(CFG_BYTES),
        .IDX_W(IDX_W)
    ) u_map (
        .raw_addr(st_q.addr),
        .vec_page(st_q.vecmap),
        .region(region),
        .word_idx(word_idx),
        .misaligned(misaligned)
    );

    isp_flash_array #(
        .WORDS(WORDS), .PAGE_WORDS(PAGE_WORDS), .IDX_W(IDX_W)
    ) u_array (
        .clk(clk),
        .rst_n(rst_n),
        .rd_idx(word_idx),
        .rd_data(arr_rd),
        .wr_en(arr_wr),
        .wr_idx(word_idx),
        .wr_data(st_q.data),
        .er_en(arr_er),
        .er_idx(word_idx)
    );

    // Access legality for the currently loaded command and address
    always_comb begin
        logic known, mem_op, upd_op, allow;
        known  = 1'b1;
        mem_op = 1'b0;
        upd_op = 1'b0;
        case (st_q.cmd)
            CMD_READ:                 mem_op = 1'b1;
            CMD_PROG, CMD_ERASE: begin
                mem_op = 1'b1;
                upd_op = 1'b1;
            end
            CMD_UID, CMD_CID, CMD_REMAP: ;
            default:                  known = 1'b0;
        endcase
        case (region)
            RGN_APP:  allow = st_q.boot || st_q.app_en;
            RGN_LDR:  allow = !st_q.boot && st_q.ldr_en;
            RGN_CFG:  allow = st_q.cfg_en;
            RGN_DATA: allow = 1'b1;
            default:  allow = 1'b0;
        endcase
        bad_now = !known
                  || (mem_op && (misaligned || region == RGN_NONE))
                  || (upd_op && !allow);
    end

    // Next-state logic
    always_comb begin
        logic wr_ctrl, wr_stat, wr_trig;
        st_d    = st_q;
        arr_wr  = 1'b0;
        arr_er  = 1'b0;
        wr_ctrl = bus_wr && bus_addr == OFS_CTRL;
        wr_stat = bus_wr && bus_addr == OFS_STAT;
        wr_trig = bus_wr && bus_addr == OFS_TRIG;

        if ((wr_ctrl || wr_stat) && bus_wdata[6]) begin
            st_d.fail = 1'b0;
        end
        if (!st_q.go) begin
            if (wr_ctrl) begin
                st_d.isp_en = bus_wdata[0];
                st_d.boot   = bus_wdata[1];
                st_d.app_en = bus_wdata[3];
                st_d.cfg_en = bus_wdata[4];
                st_d.ldr_en = bus_wdata[5];
            end
            if (bus_wr && bus_addr == OFS_ADDR) st_d.addr = bus_wdata;
            if (bus_wr && bus_addr == OFS_DATA) st_d.data = bus_wdata;
            if (bus_wr && bus_addr == OFS_CMD)  st_d.cmd  = bus_wdata[5:0];
            if (wr_trig && bus_wdata[0] && st_q.isp_en) begin
                st_d.go     = 1'b1;
                st_d.cnt    = CNT_LAST;
                st_d.op_bad = bad_now;
                if (bad_now) st_d.fail = 1'b1;
            end
        end else if (st_q.cnt == '0) begin
            st_d.go = 1'b0;
            if (!st_q.op_bad) begin
                case (st_q.cmd)
                    CMD_READ:  st_d.data   = arr_rd;
                    CMD_PROG:  arr_wr      = 1'b1;
                    CMD_ERASE: arr_er      = 1'b1;
                    CMD_UID:   st_d.data   = UID_BASE + {30'b0, st_q.addr[3:2]};
                    CMD_CID:   st_d.data   = CID_VALUE;
                    CMD_REMAP: st_d.vecmap = st_q.addr[20:9];
                    default: ;
                endcase
            end
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.boot <= ~CBS_VAL[1];
        end else begin
            st_q <= st_d;
        end
    end

    // Register read mux
    always_comb begin
        case (bus_addr)
            OFS_CTRL: bus_rdata = {25'b0, st_q.fail, st_q.ldr_en, st_q.cfg_en,
                                   st_q.app_en, 1'b0, st_q.boot, st_q.isp_en};
            OFS_ADDR: bus_rdata = st_q.addr;
            OFS_DATA: bus_rdata = st_q.data;
            OFS_CMD:  bus_rdata = {26'b0, st_q.cmd};
            OFS_TRIG: bus_rdata = {31'b0, st_q.go};
            OFS_DFB:  bus_rdata = APP_BYTES;
            OFS_STAT: bus_rdata = {11'b0, st_q.vecmap, 2'b0, st_q.fail,
                                   3'b0, CBS_VAL, st_q.go};
            default:  bus_rdata = '0;
        endcase
    end

    logic        go_s, en_s, fail_s, bad_s;
    logic [31:0] addr_s;
    assign go_s   = st_q.go;
    assign en_s   = st_q.isp_en;
    assign fail_s = st_q.fail;
    assign bad_s  = st_q.op_bad;
    assign addr_s = st_q.addr;

endmodule

// File: rtl/isp_flash_sva.sv
module isp_flash_sva #(
    parameter int BUSY_CYCLES = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  bus_addr,
    input logic        bus_wr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        go,
    input logic        isp_en,
    input logic        fail,
    input logic        op_bad,
    input logic [31:0] addr_q,
    input logic        arr_wr,
    input logic        arr_er
);
    logic [15:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  busy_run <= '0;
        else if (go) busy_run <= busy_run + 16'd1;
        else         busy_run <= '0;
    end

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= 16'(BUSY_CYCLES)); // R2

    AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == 8'h40 |-> (bus_rdata[0] == go && bus_rdata[6] == fail)); // R2

    AST_DISABLED_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h10 && bus_wdata[0] && !isp_en && !go) |=> !go); // R3

    AST_SINGLE_ARRAY_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_wr, arr_er})); // R5

    AST_BAD_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr || arr_er) |-> !op_bad); // R8

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !(bus_wr && (bus_addr == 8'h00 || bus_addr == 8'h40) && bus_wdata[6]))
        |=> fail); // R10

    AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (go && bus_wr && bus_addr == 8'h04) |=> $stable(addr_q)); // R11

endmodule

bind isp_flash_ctrl isp_flash_sva #(.BUSY_CYCLES(BUSY_CYCLES)) u_sva (
    .clk(clk),
    .rst_n(rst_n),
    .bus_addr(bus_addr),
    .bus_wr(bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .go(go_s),
    .isp_en(en_s),
    .fail(fail_s),
    .op_bad(bad_s),
    .addr_q(addr_s),
    .arr_wr(arr_wr),
    .arr_er(arr_er)
);

// File: tb/tb_isp_flash_ctrl.sv
`timescale 1ns/1ps
module tb_isp_flash_ctrl;
    localparam int BUSY = 4;
    localparam logic [31:0] UID_B = 32'h5A00_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    isp_flash_ctrl #(.BUSY_CYCLES(BUSY), .UID_BASE(UID_B)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic bw(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic br(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic run_op(input logic [5:0] cmd, input logic [31:0] a,
                          input logic [31:0] d, output int n);
        logic [31:0] v;
        bw(8'h04, a);
        bw(8'h08, d);
        bw(8'h0C, {26'b0, cmd});
        bw(8'h10, 32'h1);
        n = 0;
        forever begin
            br(8'h10, v);
            if (!v[0] || n > 50) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_word(input logic [31:0] a, output logic [31:0] d);
        int n;
        run_op(6'h00, a, 32'h0, n);
        br(8'h08, d);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        br(8'h00, v); chk("R1 control reset", v, 32'h0);
        br(8'h04, v); chk("R1 address reset", v, 32'h0);
        br(8'h08, v); chk("R1 data reset", v, 32'h0);
        br(8'h10, v); chk("R1 trigger reset", v, 32'h0);
        br(8'h40, v); chk("R1 status reset", v, 32'h6);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        bw(8'h10, 32'h1);
        br(8'h10, v); chk("R3 trigger ignored when disabled", v, 32'h0);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        int n;
        bw(8'h00, 32'h09);
        bw(8'h04, 32'h200);
        bw(8'h0C, 32'h00);
        bw(8'h10, 32'h1);
        br(8'h40, v); chk("R2 status mirrors busy", {31'b0, v[0]}, 32'h1);
        n = 1;
        @(negedge clk);
        forever begin
            br(8'h10, v);
            if (!v[0] || n > 50) break;
            n++;
            @(negedge clk);
        end
        chk("R2 busy length", n, BUSY);
        br(8'h08, v); chk("R1 erased word reads ones", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_program();
        logic [31:0] v;
        int n;
        run_op(6'h21, 32'h100, 32'hA5A5_0F0F, n);
        read_word(32'h100, v); chk("R4 program then read", v, 32'hA5A5_0F0F);
        run_op(6'h21, 32'h100, 32'hFFFF_00FF, n);
        read_word(32'h100, v); chk("R4 program ANDs bits", v, 32'hA5A5_000F);
    endtask

    task automatic t_erase();
        logic [31:0] v;
        int n;
        run_op(6'h21, 32'h1FC, 32'h1234_5678, n);
        run_op(6'h21, 32'h200, 32'h1234_5678, n);
        run_op(6'h22, 32'h100, 32'h0, n);
        read_word(32'h100, v); chk("R5 erased page word", v, 32'hFFFF_FFFF);
        read_word(32'h1FC, v); chk("R5 erased page last word", v, 32'hFFFF_FFFF);
        read_word(32'h200, v); chk("R5 next page kept", v, 32'h1234_5678);
    endtask

    task automatic t_ids();
        logic [31:0] v;
        int n;
        run_op(6'h0B, 32'h0, 32'h0, n);
        br(8'h08, v); chk("R6 company id", v, 32'hDA);
        run_op(6'h04, 32'h4, 32'h0, n);
        br(8'h08, v); chk("R6 unique id word", v, UID_B + 32'd1);
    endtask

    task automatic t_fail();
        logic [31:0] v;
        int n;
        run_op(6'h21, 32'h102, 32'h0, n);
        chk("R8 busy length on fail", n, BUSY);
        br(8'h00, v); chk("R8 fail in control", {31'b0, v[6]}, 32'h1);
        br(8'h40, v); chk("R8 fail in status", {31'b0, v[6]}, 32'h1);
        bw(8'h00, 32'h09);
        br(8'h00, v); chk("R10 write 0 keeps fail", {31'b0, v[6]}, 32'h1);
        bw(8'h00, 32'h49);
        br(8'h00, v); chk("R10 control clear", {31'b0, v[6]}, 32'h0);
        read_word(32'h100, v); chk("R8 misaligned left word", v, 32'hFFFF_FFFF);
        run_op(6'h00, 32'h0002_0000, 32'h0, n);
        br(8'h40, v); chk("R8 out of range fail", {31'b0, v[6]}, 32'h1);
        br(8'h08, v); chk("R8 data unchanged", v, 32'h0);
        bw(8'h40, 32'h40);
        br(8'h40, v); chk("R10 status clear", {31'b0, v[6]}, 32'h0);
        run_op(6'h3F, 32'h0, 32'h0, n);
        br(8'h40, v); chk("R8 unknown command fail", {31'b0, v[6]}, 32'h1);
        bw(8'h40, 32'h40);
    endtask

    task automatic t_gate();
        logic [31:0] v;
        int n;
        bw(8'h00, 32'h01);
        run_op(6'h21, 32'h300, 32'h0, n);
        br(8'h00, v); chk("R9 application locked", {31'b0, v[6]}, 32'h1);
        bw(8'h00, 32'h41);
        read_word(32'h300, v); chk("R9 application word unchanged", v, 32'hFFFF_FFFF);
        run_op(6'h21, 32'h0030_0000, 32'h0000_00F0, n);
        br(8'h00, v); chk("R9 configuration locked", {31'b0, v[6]}, 32'h1);
        bw(8'h00, 32'h51);
        run_op(6'h21, 32'h0030_0000, 32'h0000_00F0, n);
        br(8'h00, v); chk("R9 configuration enabled no fail", {31'b0, v[6]}, 32'h0);
        read_word(32'h0030_0000, v); chk("R9 configuration written", v, 32'h0000_00F0);
        bw(8'h00, 32'h01);
        run_op(6'h21, 32'h0010_0000, 32'h0000_1234, n);
        br(8'h00, v); chk("R9 loader locked", {31'b0, v[6]}, 32'h1);
        bw(8'h00, 32'h61);
        run_op(6'h21, 32'h0010_0000, 32'h0000_1234, n);
        read_word(32'h0010_0000, v); chk("R9 loader written", v, 32'h0000_1234);
        bw(8'h00, 32'h09);
    endtask

    task automatic t_busy_lock();
        logic [31:0] v;
        bw(8'h04, 32'h200);
        bw(8'h0C, 32'h00);
        bw(8'h10, 32'h1);
        bw(8'h04, 32'hFFC);
        bw(8'h00, 32'h00);
        repeat (BUSY + 2) @(negedge clk);
        br(8'h04, v); chk("R11 address locked while busy", v, 32'h200);
        br(8'h00, v); chk("R11 control locked while busy", v, 32'h09);
    endtask

    task automatic t_remap();
        logic [31:0] v;
        int n;
        run_op(6'h2E, 32'h400, 32'h0, n);
        br(8'h40, v); chk("R7 page in status", {20'b0, v[20:9]}, 32'h2);
        run_op(6'h21, 32'h004, 32'h0BAD_F00D, n);
        read_word(32'h004, v); chk("R7 read through window", v, 32'h0BAD_F00D);
        run_op(6'h2E, 32'h0, 32'h0, n);
        read_word(32'h004, v); chk("R7 low word untouched", v, 32'hFFFF_FFFF);
        read_word(32'h404, v); chk("R7 physical word programmed", v, 32'h0BAD_F00D);
    endtask

    task automatic t_dfba();
        logic [31:0] v;
        bw(8'h14, 32'hFFFF);
        br(8'h14, v); chk("R12 data base read-only", v, 32'h400);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_busy();
        t_program();
        t_erase();
        t_ids();
        t_fail();
        t_gate();
        t_busy_lock();
        t_remap();
        t_dfba();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule